// File: doc/BRIEF.md
# Partition-Restricted Set-Associative Cache

This block is a set-associative data cache in which every way is treated as a separate partition. Each load or store carries an address, a per-way partition mask and a restrict flag. The flag and mask decide which ways have their tag and data arrays activated during lookup. The mask alone decides which ways may receive a new line on a miss. Software can therefore keep unrelated data streams apart, and a reference whose partitions are known can probe one or two ways instead of all of them.

Lines are 32 bytes. The cache uses write-back with write-allocate and keeps a dirty bit per line. On a miss the requester is stalled. A dirty victim is first written out as eight 32-bit words. The new line is then read in as eight words. After that the held request is looked up again and completes as a hit. A per-way enable output shows which ways were activated in each lookup cycle, so array activity can be counted from outside the block.

Top module: `part_cache`

## Requirements
- R1: After reset every line is invalid. While no request is presented, `req_ready_o`, `mem_req_o` and `way_en_o` are all 0.
- R2: In a lookup cycle with `req_restrict_i`=1 and a non-zero mask, `way_en_o` equals `req_mask_i`, and only those ways can hit. `way_en_o` is 0 in every cycle without a lookup.
- R3: In a lookup cycle with `req_restrict_i`=0, or with an all-zero mask, `way_en_o` is all ones.
- R4: A hit raises `req_ready_o` in the lookup cycle, with the addressed word on `req_rdata_o` in that same cycle. A valid matching line that sits in an unprobed way does not hit.
- R5: The victim on a miss is taken only from the ways whose mask bit is 1, whatever `req_restrict_i` is; an all-zero mask makes every way eligible. The lowest-index invalid eligible way is taken first; otherwise the least recently used eligible way is taken.
- R6: Every hit and every completed fill makes the touched way the most recent in its set and keeps the relative order of the other ways. After reset way 0 is the most recent and the highest way the least recent.
- R7: A store hit writes the word and marks the line dirty without any memory traffic. A store miss first fills the line and then writes the word.
- R8: A dirty victim is written out before the refill as eight writes (`mem_we_o`=1) to word addresses 0 to 7 of the victim line, in ascending order. A clean or invalid victim causes no writes.
- R9: A fill is eight reads of word addresses 0 to 7 of the requested line, in ascending order. A word moves in each cycle in which both `mem_req_o` and `mem_ready_i` are high, and the address holds while `mem_ready_i` is low. With `mem_ready_i` held high, an access takes 1 cycle on a hit, 10 cycles on a miss with a clean victim and 18 cycles on a miss with a dirty victim.
- R10: Address fields are as follows. Bits [1:0] are ignored. Bits [4:2] select the word in the line. The next log2(NUM_SETS) bits select the set, and the remaining upper bits form the tag. Every `mem_addr_o` has bits [1:0] equal to 0.
- R11: When several probed ways hold the same tag, the lowest-index way supplies read data, takes store data and is touched for LRU.
- R12: The requester holds its request stable until `req_ready_o` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Store data |
| req_mask_i | input | NUM_WAYS | Partition mask, one bit per way |
| req_restrict_i | input | 1 | 1 = probe only the masked ways |
| req_ready_o | output | 1 | Access completes this cycle |
| req_rdata_o | output | 32 | Load data, valid with req_ready_o |
| way_en_o | output | NUM_WAYS | Ways activated in this lookup cycle |
| mem_req_o | output | 1 | Backing-memory word transfer requested |
| mem_we_o | output | 1 | 1 = write-back word, 0 = fill read |
| mem_addr_o | output | ADDR_W | Word-aligned memory address |
| mem_wdata_o | output | 32 | Write-back data |
| mem_rdata_i | input | 32 | Fill data, sampled when mem_ready_i is high |
| mem_ready_i | input | 1 | Memory accepts or delivers the word this cycle |

## Verification
The bench builds the cache with four ways, four sets and a 16-bit address. With only four sets and a handful of tags, conflict misses, dirty evictions and victims restricted to a partial mask all occur within a few accesses. Four ways are enough to show the lowest-index choice between duplicate lines and a reordering of LRU among a subset of ways. A phase with a periodically stalling memory covers held addresses during write-back and fill, while a behavioural model tracks the cache contents and backing memory.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int LINE_BYTES = 32;
  localparam int WORD_BYTES = 4;
  localparam int LINE_WORDS = LINE_BYTES / WORD_BYTES;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int WIDX_W     = $clog2(LINE_WORDS);
  localparam int DATA_W     = 8 * WORD_BYTES;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL
  } prc_state_e;
endpackage

// File: rtl/prc_probe.sv
module prc_probe #(
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = 20,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] way_tag_i,
  input  logic [NUM_WAYS-1:0]            way_valid_i,
  input  logic [TAG_W-1:0]               tag_i,
  input  logic [NUM_WAYS-1:0]            mask_i,
  input  logic                           restrict_i,
  input  logic                           lookup_i,
  output logic [NUM_WAYS-1:0]            probe_o,
  output logic                           hit_o,
  output logic [WAY_W-1:0]               hit_way_o
);
  logic [NUM_WAYS-1:0] sel;
  logic [NUM_WAYS-1:0] hit_vec;

  always_comb begin
    sel     = (restrict_i && (|mask_i)) ? mask_i : '1;
    probe_o = lookup_i ? sel : '0;
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign hit_vec[w] = probe_o[w] && way_valid_i[w] && (way_tag_i[w] == tag_i);
  end

  assign hit_o = |hit_vec;

  // lowest index wins when duplicates exist
  always_comb begin
    hit_way_o = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/prc_victim.sv
module prc_victim #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0][WAY_W-1:0] age_i,
  input  logic [NUM_WAYS-1:0]            valid_i,
  input  logic [NUM_WAYS-1:0]            mask_i,
  output logic [WAY_W-1:0]               victim_o
);
  logic [NUM_WAYS-1:0] elig;
  logic                have_inv;
  logic [WAY_W-1:0]    inv_way;
  logic                have_old;
  logic [WAY_W-1:0]    old_way;
  logic [WAY_W-1:0]    old_age;

  assign elig = (|mask_i) ? mask_i : '1;

  always_comb begin
    have_inv = 1'b0;
    inv_way  = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (elig[w] && !valid_i[w]) begin
        have_inv = 1'b1;
        inv_way  = WAY_W'(w);
      end
    end
  end

  always_comb begin
    have_old = 1'b0;
    old_way  = '0;
    old_age  = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (elig[w] && (!have_old || age_i[w] > old_age)) begin
        have_old = 1'b1;
        old_way  = WAY_W'(w);
        old_age  = age_i[w];
      end
    end
  end

  assign victim_o = have_inv ? inv_way : old_way;
endmodule

// File: rtl/prc_lru.sv
module prc_lru #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [SET_W-1:0]               set_i,
  input  logic                           touch_i,
  input  logic [WAY_W-1:0]               touch_way_i,
  output logic [NUM_WAYS-1:0][WAY_W-1:0] ages_o
);
  // age 0 = most recent; ages in a set form a permutation
  logic [NUM_WAYS-1:0][WAY_W-1:0] age_q [NUM_SETS];

  assign ages_o = age_q[set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (touch_i) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i) begin
          age_q[set_i][w] <= '0;
        end else if (age_q[set_i][w] < age_q[set_i][touch_way_i]) begin
          age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/part_cache.sv
module part_cache
  import prc_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  parameter int ADDR_W   = 32,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int TAG_W   = ADDR_W - SET_W - OFF_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_we_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [NUM_WAYS-1:0] req_mask_i,
  input  logic                req_restrict_i,
  output logic                req_ready_o,
  output logic [DATA_W-1:0]   req_rdata_o,
  output logic [NUM_WAYS-1:0] way_en_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic                mem_ready_i
);
  logic [TAG_W-1:0]    tag_q   [NUM_WAYS][NUM_SETS];
  logic [NUM_SETS-1:0] valid_q [NUM_WAYS];
  logic [NUM_SETS-1:0] dirty_q [NUM_WAYS];
  logic [DATA_W-1:0]   data_q  [NUM_WAYS][NUM_SETS][LINE_WORDS];

  prc_state_e        state_q;
  logic [WAY_W-1:0]  vict_q;
  logic [WIDX_W-1:0] cnt_q;

  logic [TAG_W-1:0]  req_tag;
  logic [SET_W-1:0]  req_set;
  logic [WIDX_W-1:0] req_word;
  logic              unused_addr_bits;

  assign req_tag          = req_addr_i[ADDR_W-1 -: TAG_W];
  assign req_set          = req_addr_i[OFF_W +: SET_W];
  assign req_word         = req_addr_i[2 +: WIDX_W];
  assign unused_addr_bits = ^req_addr_i[1:0];

  logic [NUM_WAYS-1:0][TAG_W-1:0] set_tags;
  logic [NUM_WAYS-1:0]            set_valid;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
    assign set_tags[w]  = tag_q[w][req_set];
    assign set_valid[w] = valid_q[w][req_set];
  end

  logic                           lookup;
  logic                           hit;
  logic [WAY_W-1:0]               hit_way;
  logic [NUM_WAYS-1:0][WAY_W-1:0] ages;
  logic [WAY_W-1:0]               victim;
  logic                           fill_last;
  logic                           touch;
  logic [WAY_W-1:0]               touch_way;

  assign lookup = req_valid_i && (state_q == ST_IDLE);

  prc_probe #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) i_probe (
    .way_tag_i  (set_tags),
    .way_valid_i(set_valid),
    .tag_i      (req_tag),
    .mask_i     (req_mask_i),
    .restrict_i (req_restrict_i),
    .lookup_i   (lookup),
    .probe_o    (way_en_o),
    .hit_o      (hit),
    .hit_way_o  (hit_way)
  );

  prc_victim #(.NUM_WAYS(NUM_WAYS)) i_victim (
    .age_i   (ages),
    .valid_i (set_valid),
    .mask_i  (req_mask_i),
    .victim_o(victim)
  );

  assign fill_last = (state_q == ST_FILL) && mem_ready_i && (&cnt_q);
  assign touch     = req_ready_o || fill_last;
  assign touch_way = (state_q == ST_FILL) ? vict_q : hit_way;

  prc_lru #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) i_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (req_set),
    .touch_i    (touch),
    .touch_way_i(touch_way),
    .ages_o     (ages)
  );

  assign req_ready_o = hit;
  assign req_rdata_o = data_q[hit_way][req_set][req_word];

  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_EVICT);
  assign mem_addr_o  = (state_q == ST_EVICT)
                       ? {tag_q[vict_q][req_set], req_set, cnt_q, 2'b00}
                       : {req_tag, req_set, cnt_q, 2'b00};
  assign mem_wdata_o = data_q[vict_q][req_set][cnt_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vict_q  <= '0;
      cnt_q   <= '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
        valid_q[w] <= '0;
        dirty_q[w] <= '0;
      end
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (lookup && !hit) begin
            vict_q <= victim;
            cnt_q  <= '0;
            if (valid_q[victim][req_set] && dirty_q[victim][req_set]) state_q <= ST_EVICT;
            else state_q <= ST_FILL;
          end
          if (req_ready_o && req_we_i) dirty_q[hit_way][req_set] <= 1'b1;
        end
        ST_EVICT: begin
          if (mem_ready_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (&cnt_q) state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ready_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (&cnt_q) begin
              tag_q[vict_q][req_set]   <= req_tag;
              valid_q[vict_q][req_set] <= 1'b1;
              dirty_q[vict_q][req_set] <= 1'b0;
              state_q                  <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if ((state_q == ST_FILL) && mem_ready_i) begin
      data_q[vict_q][req_set][cnt_q] <= mem_rdata_i;
    end else if (req_ready_o && req_we_i) begin
      data_q[hit_way][req_set][req_word] <= req_wdata_i;
    end
  end
endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
  parameter int NUM_WAYS = 4,
  parameter int ADDR_W   = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_restrict_i,
  input logic [NUM_WAYS-1:0] req_mask_i,
  input logic                req_ready_o,
  input logic [NUM_WAYS-1:0] way_en_o,
  input logic                mem_req_o,
  input logic                mem_we_o,
  input logic                mem_ready_i,
  input logic [ADDR_W-1:0]   mem_addr_o
);
  // R2: restricted lookups never activate ways outside the mask
  a_r2_probe_in_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_restrict_i && (|req_mask_i)) |-> ((way_en_o & ~req_mask_i) == '0));

  // R2: no activation without a request
  a_r2_no_idle_probe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (way_en_o != '0) |-> req_valid_i);

  // R3: unrestricted lookups activate every way
  a_r3_full_probe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_restrict_i && (way_en_o != '0)) |-> (&way_en_o));

  // R4: completion only from a probed way
  a_r4_ready_needs_probe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (way_en_o != '0));

  // R7: no memory traffic in a completing cycle
  a_r7_quiet_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o);

  // R10: word-aligned memory addresses
  a_r10_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  // R9: address held while memory stalls
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R9: ascending word order within a line
  a_r9_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && (mem_addr_o[4:2] != 3'd7))
      |=> (mem_req_o && (mem_addr_o == $past(mem_addr_o) + ADDR_W'(4))));

  // R8: write-back is followed directly by the fill
  a_r8_evict_then_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ready_i && (mem_addr_o[4:2] == 3'd7))
      |=> (mem_req_o && !mem_we_o));
endmodule

bind part_cache prc_checker #(.NUM_WAYS(NUM_WAYS), .ADDR_W(ADDR_W)) i_prc_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_restrict_i(req_restrict_i),
  .req_mask_i    (req_mask_i),
  .req_ready_o   (req_ready_o),
  .way_en_o      (way_en_o),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .mem_ready_i   (mem_ready_i),
  .mem_addr_o    (mem_addr_o)
);

// File: tb/test_part_cache.sv
module test_part_cache;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int NS = 4;
  localparam int AW = 16;
  localparam int SW = 2;
  localparam int TW = AW - SW - 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [NW-1:0] req_mask = '0;
  logic          req_restrict = 1'b0;
  logic          req_ready;
  logic [31:0]   req_rdata;
  logic [NW-1:0] way_en;
  logic          mem_req;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic          mem_ready = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  part_cache #(.NUM_WAYS(NW), .NUM_SETS(NS), .ADDR_W(AW)) i_part_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_mask_i(req_mask), .req_restrict_i(req_restrict),
    .req_ready_o(req_ready), .req_rdata_o(req_rdata), .way_en_o(way_en),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] seed_word(input int a);
    return (32'(a) * 32'h0001_0003) ^ 32'hC0DE_0000;
  endfunction

  // bench-side backing memory (driven by the design's traffic)
  logic [31:0] smem [int];
  bit  stall_mode = 1'b0;
  int  cyc = 0;
  int  wr_cnt = 0;
  int  rd_cnt = 0;
  int  wb_first = -1;

  always @(negedge clk) begin
    cyc++;
    #1;
    mem_ready = !stall_mode || (cyc % 3 != 0);
    #1;
    mem_rdata = smem.exists(int'(mem_addr)) ? smem[int'(mem_addr)] : seed_word(int'(mem_addr));
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        if (wr_cnt == 0) wb_first = int'(mem_addr);
        smem[int'(mem_addr)] = mem_wdata;
        wr_cnt++;
      end else begin
        rd_cnt++;
      end
    end
  end

  // behavioural reference
  int          m_tag   [NW][NS];
  bit          m_val   [NW][NS];
  bit          m_dirty [NW][NS];
  logic [31:0] m_data  [NW][NS][8];
  int          m_stamp [NW][NS];
  int          tick = 100;
  logic [31:0] mmem [int];

  function automatic logic [31:0] m_rd(input int a);
    return mmem.exists(a) ? mmem[a] : seed_word(a);
  endfunction

  function automatic int line_addr(input int tag, input int set, input int word);
    return (tag << 7) | (set << 5) | (word << 2);
  endfunction

  function automatic int m_lookup(input int tag, input int set, input logic [NW-1:0] probe);
    for (int w = 0; w < NW; w++) begin
      if (probe[w] && m_val[w][set] && m_tag[w][set] == tag) return w;
    end
    return -1;
  endfunction

  task automatic access(input bit we, input int tag, input int set, input int word,
                        input logic [31:0] wd, input logic [NW-1:0] mask,
                        input bit rs, input string req);
    logic [NW-1:0] probe;
    logic [NW-1:0] elig;
    int hw, v, n, exp_wb, vt, best;
    probe  = (rs && mask != '0) ? mask : '1;
    elig   = (mask != '0) ? mask : '1;
    hw     = m_lookup(tag, set, probe);
    exp_wb = 0;
    v      = -1;
    vt     = 0;
    if (hw < 0) begin
      for (int w = NW - 1; w >= 0; w--) if (elig[w] && !m_val[w][set]) v = w;
      if (v < 0) begin
        best = 0;
        for (int w = 0; w < NW; w++) begin
          if (elig[w] && (v < 0 || m_stamp[w][set] < best)) begin
            v = w;
            best = m_stamp[w][set];
          end
        end
      end
      if (m_val[v][set] && m_dirty[v][set]) exp_wb = 8;
      vt = m_tag[v][set];
    end
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0; wb_first = -1;
    req_valid = 1'b1; req_we = we; req_wdata = wd; req_mask = mask; req_restrict = rs;
    req_addr = AW'(line_addr(tag, set, word));
    #1;
    chk(way_en == probe, rs ? "R2" : "R3", "probe", 32'(way_en), 32'(probe));
    chk(req_ready == (hw >= 0), "R4", "first-cycle hit", 32'(req_ready), 32'(hw >= 0));
    n = 1;
    while (!req_ready && n < 200) begin
      @(negedge clk);
      #1;
      n++;
    end
    // model update
    if (hw < 0) begin
      if (exp_wb != 0) for (int k = 0; k < 8; k++) mmem[line_addr(vt, set, k)] = m_data[v][set][k];
      for (int k = 0; k < 8; k++) m_data[v][set][k] = m_rd(line_addr(tag, set, k));
      m_tag[v][set] = tag; m_val[v][set] = 1'b1; m_dirty[v][set] = 1'b0;
      m_stamp[v][set] = ++tick;
      hw = m_lookup(tag, set, probe);
    end
    chk(req_ready == 1'b1, "R9", "completion", 32'(req_ready), 32'd1);
    if (!we) chk(req_rdata == m_data[hw][set][word], req, "rdata", req_rdata, m_data[hw][set][word]);
    m_stamp[hw][set] = ++tick;
    if (we) begin
      m_data[hw][set][word] = wd;
      m_dirty[hw][set] = 1'b1;
    end
    if (!stall_mode) begin
      chk(n == ((v < 0) ? 1 : (exp_wb != 0 ? 18 : 10)), "R9", "latency", 32'(n),
          32'((v < 0) ? 1 : (exp_wb != 0 ? 18 : 10)));
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    chk(wr_cnt == exp_wb, "R8", "writeback words", 32'(wr_cnt), 32'(exp_wb));
    chk(rd_cnt == ((v < 0) ? 0 : 8), "R9", "fill words", 32'(rd_cnt), 32'((v < 0) ? 0 : 8));
    if (exp_wb != 0)
      chk(wb_first == line_addr(vt, set, 0), "R8", "writeback addr", 32'(wb_first),
          32'(line_addr(vt, set, 0)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R9 act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int w = 0; w < NW; w++) begin
      for (int s = 0; s < NS; s++) begin
        m_val[w][s] = 1'b0; m_dirty[w][s] = 1'b0; m_tag[w][s] = 0;
        m_stamp[w][s] = NW - w;
        for (int k = 0; k < 8; k++) m_data[w][s][k] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    // R1: quiet after reset
    chk(req_ready == 1'b0, "R1", "ready", 32'(req_ready), 32'd0);
    chk(mem_req == 1'b0, "R1", "mem_req", 32'(mem_req), 32'd0);
    chk(way_en == '0, "R1", "way_en", 32'(way_en), 32'd0);

    // R1 R3 R5: cold miss fills way 0, all ways probed
    access(1'b0, 1, 0, 3, '0, 4'b0000, 1'b1, "R1");
    access(1'b0, 1, 0, 6, '0, 4'b1111, 1'b0, "R4");
    // R4 R2 R5: line in way 0 not probed; victim limited to way 1
    access(1'b0, 1, 0, 2, '0, 4'b0010, 1'b1, "R4");
    // R11 R7: store hits lowest duplicate without traffic
    access(1'b1, 1, 0, 2, 32'hDEAD_0001, 4'b0000, 1'b0, "R11");
    access(1'b0, 1, 0, 2, '0, 4'b0010, 1'b1, "R11");
    access(1'b0, 1, 0, 2, '0, 4'b1111, 1'b0, "R11");
    // R10: address low bits ignored
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_mask = '0; req_restrict = 1'b0;
    req_addr = AW'(line_addr(1, 0, 2) | 3);
    #1;
    chk(req_ready && req_rdata == 32'hDEAD_0001, "R10", "unaligned read", req_rdata, 32'hDEAD_0001);
    @(posedge clk); #1; req_valid = 1'b0;

    // R6 R5: fill set 1, reorder LRU, evict
    for (int t = 2; t < 6; t++) access(1'b0, t, 1, 0, '0, 4'b0000, 1'b0, "R5");
    access(1'b1, 2, 1, 4, 32'h1234_5678, 4'b0000, 1'b0, "R7");
    access(1'b0, 3, 1, 1, '0, 4'b0000, 1'b0, "R6");
    access(1'b0, 6, 1, 1, '0, 4'b0000, 1'b0, "R6");
    // R5: victim only from mask 1100 even when unrestricted probe
    access(1'b0, 7, 1, 5, '0, 4'b1100, 1'b0, "R5");
    access(1'b0, 8, 1, 5, '0, 4'b0101, 1'b1, "R5");
    // R8 R7: dirty eviction then reread evicted stored word
    access(1'b1, 8, 1, 7, 32'hCAFE_F00D, 4'b0001, 1'b1, "R7");
    access(1'b0, 9, 1, 0, '0, 4'b0001, 1'b1, "R8");
    access(1'b0, 8, 1, 7, '0, 4'b0001, 1'b1, "R8");
    // R7: store miss allocates then writes
    access(1'b1, 12, 2, 3, 32'h0BAD_BEEF, 4'b0000, 1'b0, "R7");
    access(1'b0, 12, 2, 3, '0, 4'b0000, 1'b0, "R7");

    // R9 R12: stalled memory, pseudo-random traffic
    stall_mode = 1'b1;
    r = 32'h1357_9BDF;
    for (int i = 0; i < 300; i++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      access(r[0], int'(r[6:4] % 6), int'(r[9:8]), int'(r[12:10]), r ^ 32'(i),
             NW'(r[19:16]), r[20], "R12");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule